// File: doc/BRIEF.md
# Pipelined converter stage-code alignment and redundant-digit correction

This block sits behind the analog front end of a nine-stage pipelined converter. Every stage produces a 2-bit digital code per conversion. The codes for one input sample do not arrive together: each stage reports its code one clock later than the stage in front of it. The block pushes each stage's code through a staircase of registers. The first stage gets the longest delay and the last stage gets a single register, so that all nine codes of one sample meet in the same cycle.

The aligned codes are then merged by redundant-digit correction. Each code is placed one bit to the right of the code from the stage before it, and the overlapping columns are summed in one wide adder. The 10-bit result is captured in an output register together with a valid flag. The first eight stages are 1.5-bit stages and may only produce three codes. If one of them reports the fourth code, that code is folded to the highest legal code and a sticky error flag is raised. The last stage is a 2-bit flash stage and uses all four codes. The redundancy means comparator offsets smaller than a quarter of the reference do not disturb the final word.

Top module: `stage_code_aligner`

## Requirements
- R1: The stage code bus `stg_code` carries stage k (k = 0 to 8) in bits [2k+1:2k]. Stage 0 is the most significant stage. For any one sample, the stage k code is presented k clocks after stage 0's code. `in_valid` is high in the same cycle as stage 0's code.
- R2: `out_valid` goes high, carrying that sample's word, right after the tenth rising edge, counting the edge that samples `in_valid` as the first. Each valid sample gives exactly one output, and outputs come out in order.
- R3: `out_word` equals the sum over k of code_k multiplied by 2^(8-k). A sum above 1023 would be held at 1023 instead of wrapping. With legal or folded codes, the largest possible sum is exactly 1023.
- R4: The stage 8 code is added at face value for all four values 00, 01, 10 and 11.
- R5: For stages 0 to 7, a code of 11 in a valid sample is treated as 10 when the word is formed.
- R6: `code_err` goes high together with the output of the first valid sample that carried a code of 11 on any of stages 0 to 7. It then stays high until reset. A code of 11 in a cycle that belongs to no valid sample does not set it.
- R7: In a cycle where no aligned sample is completed, `out_valid` is low and `out_word` keeps its last value.
- R8: The synchronous active-high reset `rst` sets `out_word` to 0 and clears `out_valid` and `code_err`. It also empties the delay pipeline, so no sample launched before the reset ever produces an output.
- R9: For an analog input quantized by ideal 1.5-bit stages followed by a 2-bit flash, the corrected word equals the ideal 10-bit quantization of the input. This still holds when the comparator thresholds are offset by less than a quarter of the reference.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks that stage 0's code belongs to a new sample |
| stg_code | input | 18 | Nine 2-bit stage codes, stage k in bits [2k+1:2k] |
| out_word | output | 10 | Corrected conversion result |
| out_valid | output | 1 | `out_word` holds a newly completed sample |
| code_err | output | 1 | Sticky flag: a 1.5-bit stage reported code 11 |

## Verification
The bench drives a behavioural model of the stage residues with random inputs and bubbles. It compares every word against the ideal quantization, both with exact thresholds and with thresholds offset by up to 1000 of 4096 reference units. A deskew staircase with any step missing or extra would mix codes from neighbouring samples, and the random words would disagree. Full scale, with every 1.5-bit stage at 10 and the flash stage at 11, must give 1023. A design that folded the last stage's 11, or that wrapped the sum, would give a smaller word. The bench also feeds code 11 on bubble cycles, where a design that does not gate the error flag by the aligned valid would raise `code_err` too early. It also resets with samples in flight, where a valid pipeline that is not cleared would let a stale word appear afterwards.

// File: rtl/stage_align_pkg.sv
package stage_align_pkg;

    localparam int STAGES_DEF = 9;
    localparam int CODE_W     = 2;

    typedef enum logic [1:0] {
        SC_LOW     = 2'b00,
        SC_MID     = 2'b01,
        SC_HIGH    = 2'b10,
        SC_ILLEGAL = 2'b11
    } half_code_e;

    // Left shift applied to stage k's code in the overlap adder.
    function automatic int stage_shift(input int nstg, input int k);
        return nstg - 1 - k;
    endfunction

endpackage

// File: rtl/sca_deskew.sv
module sca_deskew
    import stage_align_pkg::*;
#(
    parameter int NSTG = STAGES_DEF,
    parameter int CW   = CODE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [NSTG*CW-1:0] raw_code,
    output logic [NSTG*CW-1:0] aligned_code,
    output logic               aligned_valid
);

    // Valid travels alongside stage 0, which has the deepest path.
    logic [NSTG-1:0] vline;

    always_ff @(posedge clk) begin
        if (rst) begin
            vline <= '0;
        end else begin
            vline <= {vline[NSTG-2:0], in_valid};
        end
    end

    assign aligned_valid = vline[NSTG-1];

    // Staircase: stage k arrives k clocks late, so it needs NSTG-k registers.
    for (genvar k = 0; k < NSTG; k++) begin : g_row
        localparam int DEPTH = NSTG - k;
        logic [CW-1:0] sr [DEPTH];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < DEPTH; i++) begin
                    sr[i] <= '0;
                end
            end else begin
                sr[0] <= raw_code[k*CW +: CW];
                for (int i = 1; i < DEPTH; i++) begin
                    sr[i] <= sr[i-1];
                end
            end
        end

        assign aligned_code[k*CW +: CW] = sr[DEPTH-1];
    end

endmodule

// File: rtl/sca_sanitize.sv
module sca_sanitize
    import stage_align_pkg::*;
#(
    parameter int NSTG = STAGES_DEF,
    parameter int CW   = CODE_W
) (
    input  logic               valid,
    input  logic [NSTG*CW-1:0] code_in,
    output logic [NSTG*CW-1:0] code_out,
    output logic               bad_code
);

    logic [NSTG-1:0] illegal;

    for (genvar k = 0; k < NSTG; k++) begin : g_stage
        if (k < NSTG - 1) begin : g_half
            // 1.5-bit stage: three legal codes, the fourth is folded.
            always_comb begin
                illegal[k] = 1'b0;
                unique case (half_code_e'(code_in[k*CW +: CW]))
                    SC_LOW:  code_out[k*CW +: CW] = SC_LOW;
                    SC_MID:  code_out[k*CW +: CW] = SC_MID;
                    SC_HIGH: code_out[k*CW +: CW] = SC_HIGH;
                    SC_ILLEGAL: begin
                        code_out[k*CW +: CW] = SC_HIGH;
                        illegal[k]           = 1'b1;
                    end
                endcase
            end
        end else begin : g_flash
            // Final flash stage: every code is legal.
            assign code_out[k*CW +: CW] = code_in[k*CW +: CW];
            assign illegal[k]           = 1'b0;
        end
    end

    assign bad_code = valid & (|illegal);

endmodule

// File: rtl/sca_overlap_sum.sv
module sca_overlap_sum
    import stage_align_pkg::*;
#(
    parameter int NSTG = STAGES_DEF,
    parameter int CW   = CODE_W,
    parameter int OW   = NSTG + 1
) (
    input  logic [NSTG*CW-1:0] code_in,
    output logic [OW-1:0]      word,
    output logic               carry_out
);

    localparam int SW = OW + 1;

    logic [SW-1:0] acc;

    always_comb begin
        acc = '0;
        for (int k = 0; k < NSTG; k++) begin
            acc = acc + (SW'(code_in[k*CW +: CW]) << stage_shift(NSTG, k));
        end
    end

    assign carry_out = acc[SW-1];
    assign word      = carry_out ? {OW{1'b1}} : acc[OW-1:0];

endmodule

// File: rtl/stage_code_aligner.sv
module stage_code_aligner
    import stage_align_pkg::*;
#(
    parameter int NSTG = STAGES_DEF,
    parameter int CW   = CODE_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [NSTG*CW-1:0]    stg_code,
    output logic [NSTG:0]         out_word,
    output logic                  out_valid,
    output logic                  code_err
);

    localparam int OW = NSTG + 1;

    logic [NSTG*CW-1:0] al_code;
    logic               al_valid;
    logic [NSTG*CW-1:0] clean_code;
    logic               bad_code;
    logic [OW-1:0]      sum_word;
    logic               sum_carry;

    sca_deskew #(.NSTG(NSTG), .CW(CW)) u_deskew (
        .clk           (clk),
        .rst           (rst),
        .in_valid      (in_valid),
        .raw_code      (stg_code),
        .aligned_code  (al_code),
        .aligned_valid (al_valid)
    );

    sca_sanitize #(.NSTG(NSTG), .CW(CW)) u_sanitize (
        .valid    (al_valid),
        .code_in  (al_code),
        .code_out (clean_code),
        .bad_code (bad_code)
    );

    sca_overlap_sum #(.NSTG(NSTG), .CW(CW), .OW(OW)) u_sum (
        .code_in   (clean_code),
        .word      (sum_word),
        .carry_out (sum_carry)
    );

    // Output register: all bits of the corrected word captured together.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_word  <= '0;
            out_valid <= 1'b0;
            code_err  <= 1'b0;
        end else begin
            out_valid <= al_valid;
            if (al_valid) begin
                out_word <= sum_word;
            end
            if (bad_code) begin
                code_err <= 1'b1;
            end
        end
    end

    // R8: outputs cleared after reset
    p_reset_clear_r8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (out_word == '0 && !out_valid && !code_err));

    // R6: error flag is sticky
    p_sticky_err_r6: assert property (@(posedge clk) disable iff (rst)
        $past(code_err) |-> code_err);

    // R7: word held when no aligned sample completed
    p_hold_word_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(al_valid)) |-> $stable(out_word));

    // R2: output valid follows the aligned sample by one register
    p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(al_valid)));

    // R3: legal and folded codes never overflow the word
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        al_valid |-> !sum_carry);

endmodule

// File: tb/sim_stage_code_aligner.sv
module sim_stage_code_aligner;

    localparam int NSTG = 9;
    localparam int VREF = 4096;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [NSTG*2-1:0] stg_code = '0;
    logic [NSTG:0]     out_word;
    logic              out_valid;
    logic              code_err;

    always #10 clk = ~clk;

    stage_code_aligner u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .stg_code  (stg_code),
        .out_word  (out_word),
        .out_valid (out_valid),
        .code_err  (code_err)
    );

    typedef struct {
        int    word;
        bit    err;
        int    launch;
        string tag;
    } exp_t;

    exp_t     sbq[$];
    int       checks = 0;
    int       fails = 0;
    int       ecount = 0;
    bit       err_model = 0;
    int       last_word = 0;
    bit       finished = 0;
    logic [1:0] hist [NSTG][NSTG];
    logic [1:0] nc [NSTG];
    int       off_hi [NSTG-1];
    int       off_lo [NSTG-1];

    always @(posedge clk) ecount <= ecount + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (edge %0d)", tag, act, exp, ecount);
        end
    endtask

    // Driver: one call per cycle, launches nc[] as stage codes of a new sample.
    task automatic step(input bit v, input int exp_word, input bit has_bad, input string tag);
        exp_t it;
        @(negedge clk);
        for (int j = NSTG - 1; j > 0; j--) begin
            for (int s = 0; s < NSTG; s++) hist[j][s] = hist[j-1][s];
        end
        for (int s = 0; s < NSTG; s++) hist[0][s] = nc[s];
        for (int k = 0; k < NSTG; k++) stg_code[k*2 +: 2] = hist[k][k];
        in_valid = v;
        if (v) begin
            err_model = err_model | has_bad;
            it.word   = exp_word;
            it.err    = err_model;
            it.launch = ecount + 1;
            it.tag    = tag;
            sbq.push_back(it);
        end
    endtask

    task automatic bubble();
        for (int s = 0; s < NSTG; s++) nc[s] = 2'($urandom_range(3));
        step(1'b0, 0, 1'b0, "");
    endtask

    // Directed codes: expected value computed from R3/R4/R5 weighting.
    task automatic push_codes(input string tag);
        int  sum = 0;
        bit  bad = 0;
        for (int k = 0; k < NSTG; k++) begin
            int c = int'(nc[k]);
            if (k < NSTG - 1 && c == 3) begin
                c   = 2;
                bad = 1;
            end
            sum += c << (NSTG - 1 - k);
        end
        if (sum > 1023) sum = 1023;
        step(1'b1, sum, bad, tag);
    endtask

    // Behavioural residue model; expected word is the ideal quantization (R9).
    task automatic push_analog(input int x);
        int r = x;
        for (int k = 0; k < NSTG - 1; k++) begin
            if (r > VREF/4 + off_hi[k]) begin
                nc[k] = 2'b10;
                r = 2*r - VREF;
            end else if (r < -VREF/4 + off_lo[k]) begin
                nc[k] = 2'b00;
                r = 2*r + VREF;
            end else begin
                nc[k] = 2'b01;
                r = 2*r;
            end
        end
        begin
            int f = (r + VREF) / (VREF/2);
            if (f > 3) f = 3;
            nc[NSTG-1] = 2'(f);
        end
        step(1'b1, (x + VREF) >> 3, 1'b0, "R9");
    endtask

    task automatic set_codes(input int c0, input int crest, input int clast);
        nc[0] = 2'(c0);
        for (int k = 1; k < NSTG - 1; k++) nc[k] = 2'(crest);
        nc[NSTG-1] = 2'(clast);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (out_valid) begin
                if (sbq.size() == 0) begin
                    check(1'b0, "R2/R8 unexpected out_valid", 1, 0);
                end else begin
                    exp_t it;
                    it = sbq.pop_front();
                    check(ecount == it.launch + 9, "R2 latency edge", ecount, it.launch + 9);
                    check(int'(out_word) == it.word, {it.tag, " word"}, int'(out_word), it.word);
                    check(code_err == it.err, "R6 code_err", int'(code_err), int'(it.err));
                end
                last_word = int'(out_word);
            end else begin
                check(int'(out_word) == last_word, "R7 hold", int'(out_word), last_word);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int j = 0; j < NSTG; j++)
            for (int s = 0; s < NSTG; s++) hist[j][s] = 2'b00;
        for (int k = 0; k < NSTG - 1; k++) begin
            off_hi[k] = 0;
            off_lo[k] = 0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(out_word == '0, "R8 reset word", int'(out_word), 0);
        check(!out_valid, "R8 reset valid", int'(out_valid), 0);
        check(!code_err, "R8 reset err", int'(code_err), 0);

        // R3/R4/R1 directed patterns, with garbage bubbles between (R6 gating, R7)
        set_codes(0, 0, 0); push_codes("R3 zero");
        bubble();
        set_codes(1, 0, 0); push_codes("R1 stage0 weight");
        set_codes(1, 1, 1); push_codes("R3 all mid");
        bubble(); bubble();
        set_codes(2, 2, 3); push_codes("R3 full scale");
        for (int f = 0; f < 4; f++) begin
            set_codes(0, 0, f); push_codes("R4 flash code");
        end
        for (int s = 0; s < NSTG; s++) begin
            set_codes(0, 0, 0);
            nc[s] = 2'b10;
            push_codes("R1 single stage");
        end
        repeat (3) bubble();

        // R9: ideal quantization, exact thresholds then offset thresholds
        push_analog(-VREF); push_analog(VREF - 1);
        push_analog(VREF/4); push_analog(-VREF/4); push_analog(0);
        for (int n = 0; n < 300; n++) begin
            if ($urandom_range(3) == 0) bubble();
            push_analog(int'($urandom_range(8191)) - VREF);
        end
        for (int k = 0; k < NSTG - 1; k++) begin
            off_hi[k] = int'($urandom_range(2000)) - 1000;
            off_lo[k] = int'($urandom_range(2000)) - 1000;
        end
        push_analog(-VREF); push_analog(VREF - 1);
        for (int n = 0; n < 300; n++) begin
            if ($urandom_range(3) == 0) bubble();
            push_analog(int'($urandom_range(8191)) - VREF);
        end
        repeat (12) bubble();
        check(!code_err, "R6 no err from bubbles", int'(code_err), 0);

        // R5/R6: illegal code folded, flag set and sticky
        set_codes(0, 0, 0); nc[2] = 2'b11; push_codes("R5 fold");
        set_codes(2, 3, 3); push_codes("R5 fold all");
        set_codes(0, 1, 0); push_codes("R6 sticky");
        repeat (12) bubble();
        check(code_err, "R6 still set", int'(code_err), 1);

        // R8: reset with samples in flight
        set_codes(1, 1, 1); push_codes("R8 flight");
        set_codes(2, 0, 1); push_codes("R8 flight");
        set_codes(0, 2, 2); push_codes("R8 flight");
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        sbq.delete();
        err_model = 0;
        last_word = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(!code_err, "R8 err cleared", int'(code_err), 0);
        check(out_word == '0, "R8 word cleared", int'(out_word), 0);
        repeat (15) bubble();
        set_codes(1, 0, 2); push_codes("R8 after reset");
        repeat (12) bubble();

        check(sbq.size() == 0, "R2 all outputs seen", sbq.size(), 0);
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule